// File: doc/BRIEF.md
# Programmable External Burst Read Sequencer

This block runs burst reads on an external peripheral bus for a bank that allows bursting. A requester hands over a start address, a beat count and a byte-lane mask. In the same handshake it supplies the timing of the selected bank: the chip-select offset, the output-enable offset, the wait before the first beat, the wait before each later beat and the idle gap after the burst. It also supplies two mode flags, one for byte-lane strobes and one for parity checking. The whole set is captured when the request is accepted, so the requester may change these inputs while the burst runs.

The sequencer drives the address, an active-low chip select, an active-low output enable, active-low byte strobes and an active-low final-beat marker. At each programmed sampling point it captures the 32-bit data bus, four odd-parity lane bits and the peripheral error line. The captured beat is handed back one cycle later with its error and parity status. When a new request is already waiting as a burst ends with a zero idle gap, the next burst starts at once and the bus strobes stay asserted between the two bursts.

Top module: `burst_rd_seq`

## Requirements
- R1: Out of reset the block drives ext_cs_n, ext_oe_n and ext_last_n high, drives ext_be_n to 4'hF, holds rsp_valid low and holds req_ready high.
- R2: A request is accepted on the clock edge where req_valid and req_ready are both high. Transfer cycle 0 is the next cycle, and ext_addr shows req_addr in that cycle. In every cycle of the burst, ext_be_n equals the inverse of req_be when cfg_be_mode=1 and equals 4'hF when cfg_be_mode=0.
- R3: ext_cs_n goes low in transfer cycle cfg_csn_dly. A value of 0 means cycle 0. Once low, it stays low until the final beat has been sampled.
- R4: ext_oe_n goes low in transfer cycle cfg_csn_dly+cfg_oen_dly, which is cfg_oen_dly cycles after chip select. It is never low while ext_cs_n is high.
- R5: The first beat is sampled at the clock edge that ends transfer cycle cfg_first_wait. The beat appears on rsp_valid and rsp_data in the cycle after that edge.
- R6: After each beat that is not the final one, ext_addr increases by 4 in the next cycle. That beat lasts cfg_beat_wait+1 cycles and is sampled at the edge that ends its last cycle. The burst holds req_len+1 beats.
- R7: ext_last_n is low in exactly the cycles of the final beat. rsp_last is high only with the final returned beat.
- R8: Parity is odd per byte lane: ext_par[i] together with ext_data[8i+7:8i] must hold an odd number of ones. When cfg_par_en=1, a lane that fails sets rsp_par_err and rsp_err for that beat. When cfg_par_en=0, parity is ignored and both flags stay low.
- R9: ext_err is sampled at the same edge as the data. When it is high, rsp_err is set for that beat alone.
- R10: The cycle after the final sample, ext_cs_n, ext_oe_n and ext_last_n are high. req_ready then stays low for cfg_hold cycles before it returns high.
- R11: The burst is back-to-back when req_valid is high in the final sample cycle and cfg_hold=0. In that case req_ready is high in that cycle, and the next transfer's cycle 0 follows at once. ext_cs_n stays low across the boundary. ext_oe_n stays low when the new cfg_oen_dly is 0; otherwise it goes low in new cycle cfg_oen_dly.
- R12: Timing, mode and mask inputs are captured at acceptance. Changes to them during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Burst request pending |
| req_ready | output | 1 | Request accepted on this edge if req_valid is high |
| req_addr | input | 32 | Byte address of the first beat |
| req_len | input | 4 | Number of beats minus one |
| req_be | input | 4 | Byte-lane mask, active high |
| cfg_csn_dly | input | 4 | Cycles from transfer start to chip select |
| cfg_oen_dly | input | 4 | Cycles from chip select to output enable |
| cfg_first_wait | input | 4 | First beat sampled at end of this transfer cycle |
| cfg_beat_wait | input | 4 | Later beats last this many cycles plus one |
| cfg_hold | input | 4 | Idle cycles after a burst |
| cfg_be_mode | input | 1 | Drive byte strobes during the burst |
| cfg_par_en | input | 1 | Check odd parity on every beat |
| ext_addr | output | 32 | Peripheral address |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_oe_n | output | 1 | Output enable, active low |
| ext_be_n | output | 4 | Byte strobes, active low |
| ext_last_n | output | 1 | Final-beat marker, active low |
| ext_data | input | 32 | Peripheral read data |
| ext_par | input | 4 | Parity bit per byte lane |
| ext_err | input | 1 | Peripheral error |
| rsp_valid | output | 1 | Returned beat valid for one cycle |
| rsp_data | output | 32 | Returned beat data |
| rsp_err | output | 1 | Peripheral error or parity failure on this beat |
| rsp_par_err | output | 1 | Parity failure on this beat |
| rsp_last | output | 1 | Returned beat is the final one |

## Verification
A wrong phase or wait count shows up at the ports within the beat where it occurs. A strobe moves off its cycle, rsp_valid lands on the wrong cycle, or ext_addr steps at the wrong point, so every cycle of every burst is compared against the expected strobe pattern and address. A wrong beat counter moves ext_last_n and rsp_last, and it shows on the first burst that has more than one beat. Errors in the hold counter or the back-to-back path show only at the boundary between bursts, through req_ready and the chip select staying low. Each of these is checked in the cycles right around that boundary.

// File: rtl/brs_pkg.sv
package brs_pkg;
  // Sequencer phases: idle, first beat, later beats, post-burst gap
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_NEXT  = 2'd2,
    ST_HOLD  = 2'd3
  } brs_state_e;
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DLY_W = 4,
  parameter int LEN_W = 4,
  parameter int LANES = 4,
  localparam int CNT_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LANES-1:0] req_be,
  input  logic [DLY_W-1:0] cfg_csn,
  input  logic [DLY_W-1:0] cfg_oen,
  input  logic [DLY_W-1:0] cfg_fwt,
  input  logic [DLY_W-1:0] cfg_bwt,
  input  logic [DLY_W-1:0] cfg_th,
  input  logic             cfg_bem,
  input  logic             cfg_pen,
  output brs_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DLY_W-1:0] csn_o,
  output logic [DLY_W-1:0] oen_o,
  output logic             b2b_o,
  output logic             last_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] be_o,
  output logic             bem_o,
  output logic             pen_o
);

  brs_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             b2b_q, b2b_d;

  // Captured bank settings, loaded only on acceptance
  logic [LEN_W-1:0] len_q;
  logic [LANES-1:0] be_q;
  logic [DLY_W-1:0] csn_q, oen_q, fwt_q, bwt_q, th_q;
  logic             bem_q, pen_q;

  logic first_hit, next_hit, sample, last, done, load;

  always_comb begin
    first_hit = (state_q == ST_FIRST) && (cnt_q == {1'b0, fwt_q});
    next_hit  = (state_q == ST_NEXT)  && (cnt_q == {1'b0, bwt_q});
    sample    = first_hit || next_hit;
    last      = (beat_q == len_q);
    done      = sample && last;
    req_ready = (state_q == ST_IDLE) || (done && (th_q == '0));
    load      = req_valid && req_ready;
    cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  end

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_inc;
    beat_d  = beat_q;
    addr_d  = addr_q;
    b2b_d   = b2b_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = ST_FIRST;
          cnt_d   = '0;
          beat_d  = '0;
          addr_d  = req_addr;
          b2b_d   = 1'b0;
        end
      end
      ST_FIRST, ST_NEXT: begin
        if (sample) begin
          if (!last) begin
            state_d = ST_NEXT;
            cnt_d   = '0;
            beat_d  = beat_q + 1'b1;
            addr_d  = addr_q + AW'(LANES);
          end else if (load) begin
            state_d = ST_FIRST;
            cnt_d   = '0;
            beat_d  = '0;
            addr_d  = req_addr;
            b2b_d   = 1'b1;
          end else if (th_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_HOLD;
            cnt_d   = '0;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q == ({1'b0, th_q} - 1'b1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      addr_q  <= '0;
      b2b_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      addr_q  <= addr_d;
      b2b_q   <= b2b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      be_q  <= '0;
      csn_q <= '0;
      oen_q <= '0;
      fwt_q <= '0;
      bwt_q <= '0;
      th_q  <= '0;
      bem_q <= 1'b0;
      pen_q <= 1'b0;
    end else if (load) begin
      len_q <= req_len;
      be_q  <= req_be;
      csn_q <= cfg_csn;
      oen_q <= cfg_oen;
      fwt_q <= cfg_fwt;
      bwt_q <= cfg_bwt;
      th_q  <= cfg_th;
      bem_q <= cfg_bem;
      pen_q <= cfg_pen;
    end
  end

  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
  assign csn_o    = csn_q;
  assign oen_o    = oen_q;
  assign b2b_o    = b2b_q;
  assign last_o   = last;
  assign sample_o = sample;
  assign done_o   = done;
  assign addr_o   = addr_q;
  assign be_o     = be_q;
  assign bem_o    = bem_q;
  assign pen_o    = pen_q;

  // R10: no request may be taken during the post-burst gap
  assert_hold_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !req_ready);

  // R6: a non-final sample advances the address by one bus word
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !last) |=> (addr_q == $past(addr_q) + AW'(LANES)));

endmodule

// File: rtl/brs_pins.sv
module brs_pins
  import brs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DLY_W = 4,
  parameter int LANES = 4,
  localparam int CNT_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  brs_state_e       state,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DLY_W-1:0] csn,
  input  logic [DLY_W-1:0] oen,
  input  logic             b2b,
  input  logic             last,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] be,
  input  logic             bem,
  output logic [AW-1:0]    ext_addr,
  output logic             ext_cs_n,
  output logic             ext_oe_n,
  output logic [LANES-1:0] ext_be_n,
  output logic             ext_last_n
);

  logic             in_burst, cs_on, oe_on;
  logic [CNT_W-1:0] oe_thr;

  always_comb begin
    in_burst = (state == ST_FIRST) || (state == ST_NEXT);
    // On a chained transfer chip select is already active at cycle 0
    oe_thr   = b2b ? {1'b0, oen} : ({1'b0, csn} + {1'b0, oen});
    cs_on    = (state == ST_NEXT) ||
               ((state == ST_FIRST) && (b2b || (cnt >= {1'b0, csn})));
    oe_on    = (state == ST_NEXT) ||
               ((state == ST_FIRST) && (cnt >= oe_thr));
    ext_addr   = addr;
    ext_cs_n   = !cs_on;
    ext_oe_n   = !oe_on;
    ext_last_n = !(in_burst && last);
    ext_be_n   = (in_burst && bem) ? ~be : '1;
  end

  // R4: output enable only inside an active chip select
  assert_oe_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_oe_n |-> !ext_cs_n);

endmodule

// File: rtl/brs_parity.sv
module brs_parity #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    data,
  input  logic [LANES-1:0] par,
  input  logic             enable,
  output logic             par_err
);

  logic [LANES-1:0] lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Odd parity: byte plus its lane bit must hold an odd count of ones
    assign lane_bad[g] = ~^{data[g*8 +: 8], par[g]};
  end

  assign par_err = enable && (|lane_bad);

endmodule

// File: rtl/brs_capture.sv
module brs_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          last,
  input  logic [DW-1:0] data,
  input  logic          bus_err,
  input  logic          par_err,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_par_err,
  output logic          rsp_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data    <= '0;
      rsp_err     <= 1'b0;
      rsp_par_err <= 1'b0;
      rsp_last    <= 1'b0;
    end else if (sample) begin
      rsp_data    <= data;
      rsp_err     <= bus_err || par_err;
      rsp_par_err <= par_err;
      rsp_last    <= last;
    end
  end

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LANES = 4,
  parameter int DLY_W = 4,
  parameter int LEN_W = 4,
  localparam int DW    = LANES * 8,
  localparam int CNT_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LANES-1:0] req_be,
  input  logic [DLY_W-1:0] cfg_csn_dly,
  input  logic [DLY_W-1:0] cfg_oen_dly,
  input  logic [DLY_W-1:0] cfg_first_wait,
  input  logic [DLY_W-1:0] cfg_beat_wait,
  input  logic [DLY_W-1:0] cfg_hold,
  input  logic             cfg_be_mode,
  input  logic             cfg_par_en,
  output logic [AW-1:0]    ext_addr,
  output logic             ext_cs_n,
  output logic             ext_oe_n,
  output logic [LANES-1:0] ext_be_n,
  output logic             ext_last_n,
  input  logic [DW-1:0]    ext_data,
  input  logic [LANES-1:0] ext_par,
  input  logic             ext_err,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_err,
  output logic             rsp_par_err,
  output logic             rsp_last
);

  // Asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  brs_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] csn, oen;
  logic             b2b, last, sample, done, bem, pen, par_err;
  logic [AW-1:0]    addr;
  logic [LANES-1:0] be;

  brs_ctrl #(.AW(AW), .DLY_W(DLY_W), .LEN_W(LEN_W), .LANES(LANES)) i_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
    .cfg_csn(cfg_csn_dly), .cfg_oen(cfg_oen_dly), .cfg_fwt(cfg_first_wait),
    .cfg_bwt(cfg_beat_wait), .cfg_th(cfg_hold),
    .cfg_bem(cfg_be_mode), .cfg_pen(cfg_par_en),
    .state_o(st), .cnt_o(cnt), .csn_o(csn), .oen_o(oen), .b2b_o(b2b),
    .last_o(last), .sample_o(sample), .done_o(done), .addr_o(addr),
    .be_o(be), .bem_o(bem), .pen_o(pen)
  );

  brs_pins #(.AW(AW), .DLY_W(DLY_W), .LANES(LANES)) i_pins (
    .clk(clk), .rst_n(rst_sync_n),
    .state(st), .cnt(cnt), .csn(csn), .oen(oen), .b2b(b2b), .last(last),
    .addr(addr), .be(be), .bem(bem),
    .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
    .ext_be_n(ext_be_n), .ext_last_n(ext_last_n)
  );

  brs_parity #(.LANES(LANES)) i_parity (
    .data(ext_data), .par(ext_par), .enable(pen), .par_err(par_err)
  );

  brs_capture #(.DW(DW)) i_capture (
    .clk(clk), .rst_n(rst_sync_n),
    .sample(sample), .last(last), .data(ext_data),
    .bus_err(ext_err), .par_err(par_err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_par_err(rsp_par_err), .rsp_last(rsp_last)
  );

  // R11: chip select holds across a chained burst boundary
  assert_b2b_cs_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && req_valid && req_ready) |=> !ext_cs_n);

  // R7: a beat flagged final was sampled while the final-beat marker was low
  assert_last_marker_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_last) |-> $past(!ext_last_n));

endmodule

// File: tb/test_burst_rd_seq.sv
module test_burst_rd_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_len, req_be;
  logic [3:0]  cfg_csn_dly, cfg_oen_dly, cfg_first_wait, cfg_beat_wait, cfg_hold;
  logic        cfg_be_mode, cfg_par_en;
  logic [31:0] ext_addr;
  logic        ext_cs_n, ext_oe_n, ext_last_n;
  logic [3:0]  ext_be_n;
  logic [31:0] ext_data;
  logic [3:0]  ext_par;
  logic        ext_err;
  logic        rsp_valid, rsp_err, rsp_par_err, rsp_last;
  logic [31:0] rsp_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;  // 50 MHz

  burst_rd_seq i_burst_rd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
    .cfg_csn_dly(cfg_csn_dly), .cfg_oen_dly(cfg_oen_dly),
    .cfg_first_wait(cfg_first_wait), .cfg_beat_wait(cfg_beat_wait),
    .cfg_hold(cfg_hold), .cfg_be_mode(cfg_be_mode), .cfg_par_en(cfg_par_en),
    .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
    .ext_be_n(ext_be_n), .ext_last_n(ext_last_n),
    .ext_data(ext_data), .ext_par(ext_par), .ext_err(ext_err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_par_err(rsp_par_err), .rsp_last(rsp_last)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] base, input int k);
    return {base[15:0], 16'(k)} ^ 32'h5AC3_0000;
  endfunction

  function automatic logic [3:0] odd_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~^d[i*8 +: 8];
    return p;
  endfunction

  task automatic drive_beat(input logic [31:0] d, input bit bad, input bit err);
    ext_data = d;
    ext_par  = odd_par(d) ^ {3'b000, bad};
    ext_err  = err;
  endtask

  // Check one returned beat (R5 R8 R9 R7)
  task automatic chk_rsp(input logic [31:0] d, input bit perr, input bit berr,
                         input bit lst);
    chk(rsp_valid === 1'b1, "R5 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_data === d, "R5 R6 rsp_data", 64'(rsp_data), 64'(d));
    chk({rsp_err, rsp_par_err} === {berr | perr, perr}, "R8 R9 rsp_err/rsp_par_err",
        64'({rsp_err, rsp_par_err}), 64'({berr | perr, perr}));
    chk(rsp_last === lst, "R7 rsp_last", 64'(rsp_last), 64'(lst));
  endtask

  // Full burst with per-cycle comparison of every bus strobe
  task automatic do_burst(input logic [31:0] base, input int len, input logic [3:0] be,
                          input int csn, input int oen, input int fwt, input int bwt,
                          input int th, input bit bem, input bit pen,
                          input int bad_beat, input int err_beat);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 req_ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = base; req_len = 4'(len); req_be = be;
    cfg_csn_dly = 4'(csn); cfg_oen_dly = 4'(oen); cfg_first_wait = 4'(fwt);
    cfg_beat_wait = 4'(bwt); cfg_hold = 4'(th); cfg_be_mode = bem; cfg_par_en = pen;
    for (int k = 0; k <= len; k++) begin
      int p;
      p = (k == 0) ? fwt + 1 : bwt + 1;
      for (int c = 0; c < p; c++) begin
        logic [7:0] act, exp;
        @(negedge clk);
        if (k == 0 && c == 0) begin
          // R12: scramble the settings once captured
          req_valid = 1'b0; req_addr = ~base; req_len = ~req_len; req_be = ~be;
          cfg_csn_dly = 4'hF; cfg_oen_dly = 4'hF; cfg_first_wait = 4'h0;
          cfg_beat_wait = 4'hF; cfg_hold = 4'hF; cfg_be_mode = ~bem; cfg_par_en = ~pen;
        end
        drive_beat(pat(base, k), k == bad_beat, k == err_beat);
        if (k > 0 && c == 0)
          chk_rsp(pat(base, k - 1), pen && (k - 1 == bad_beat), k - 1 == err_beat, 1'b0);
        else
          chk(rsp_valid === 1'b0, "R5 R6 no beat returned", 64'(rsp_valid), 64'd0);
        exp = {!((k > 0) || (c >= csn)), !((k > 0) || (c >= csn + oen)),
               !(k == len), (bem ? ~be : 4'hF),
               (k == len && c == p - 1 && th == 0)};
        act = {ext_cs_n, ext_oe_n, ext_last_n, ext_be_n, req_ready};
        chk(act === exp, "R2 R3 R4 R7 R12 cs/oe/last/be/ready", 64'(act), 64'(exp));
        chk(ext_addr === base + 32'(4 * k), "R2 R6 ext_addr", 64'(ext_addr),
            64'(base + 32'(4 * k)));
      end
    end
    @(negedge clk);
    drive_beat(32'h0, 1'b0, 1'b0);
    chk_rsp(pat(base, len), pen && (len == bad_beat), len == err_beat, 1'b1);
    chk({ext_cs_n, ext_oe_n, ext_last_n, ext_be_n} === 7'h7F, "R10 strobes idle",
        64'({ext_cs_n, ext_oe_n, ext_last_n, ext_be_n}), 64'h7F);
    for (int h = 0; h < th; h++) begin
      if (h > 0) @(negedge clk);
      chk(req_ready === 1'b0, "R10 req_ready low in gap", 64'(req_ready), 64'd0);
    end
    if (th > 0) @(negedge clk);
    chk(req_ready === 1'b1, "R10 req_ready back", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    chk({ext_cs_n, ext_oe_n, ext_last_n, ext_be_n, rsp_valid, req_ready} === 9'h1FD,
        "R1 reset outputs",
        64'({ext_cs_n, ext_oe_n, ext_last_n, ext_be_n, rsp_valid, req_ready}), 64'h1FD);
  endtask

  task automatic t_basic;       do_burst(32'h0000_1000, 3, 4'hF, 1, 1, 3, 1, 2, 1'b1, 1'b1, -1, -1); endtask
  task automatic t_zero_delay;  do_burst(32'h0000_2000, 2, 4'h3, 0, 0, 0, 0, 0, 1'b0, 1'b0, -1, -1); endtask
  task automatic t_single;      do_burst(32'h0000_3000, 0, 4'b0101, 2, 1, 4, 0, 1, 1'b1, 1'b0, -1, -1); endtask
  task automatic t_parity_on;   do_burst(32'h0000_4000, 2, 4'hF, 0, 1, 2, 2, 1, 1'b1, 1'b1, 1, -1); endtask
  task automatic t_parity_off;  do_burst(32'h0000_5000, 2, 4'hF, 0, 1, 2, 2, 1, 1'b1, 1'b0, 1, -1); endtask  // R8 ignored
  task automatic t_bus_err;     do_burst(32'h0000_6000, 3, 4'hC, 1, 0, 1, 1, 0, 1'b1, 1'b0, -1, 2); endtask  // R9
  task automatic t_long_hold;   do_burst(32'hFFFF_FFF8, 2, 4'hF, 3, 2, 6, 3, 5, 1'b0, 1'b1, -1, -1); endtask

  // R11: chained bursts with zero gap
  task automatic t_b2b(input int csn, input int oen, input int fwt);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h200; req_len = 4'd0; req_be = 4'hF;
    cfg_csn_dly = 4'(csn); cfg_oen_dly = 4'(oen); cfg_first_wait = 4'(fwt);
    cfg_beat_wait = 4'd0; cfg_hold = 4'd0; cfg_be_mode = 1'b1; cfg_par_en = 1'b0;
    for (int c = 0; c <= fwt; c++) begin
      @(negedge clk);
      if (c == 0) req_addr = 32'h300;
      drive_beat(32'hA0A0_0001, 1'b0, 1'b0);
    end
    chk(req_ready === 1'b1, "R11 ready in final sample cycle", 64'(req_ready), 64'd1);
    for (int c = 0; c <= fwt; c++) begin
      @(negedge clk);
      if (c == 0) begin
        req_valid = 1'b0;
        chk_rsp(32'hA0A0_0001, 1'b0, 1'b0, 1'b1);
        chk(ext_addr === 32'h300, "R11 new address", 64'(ext_addr), 64'h300);
      end
      drive_beat(32'hB0B0_0002, 1'b0, 1'b0);
      chk(ext_cs_n === 1'b0, "R11 cs held low", 64'(ext_cs_n), 64'd0);
      chk(ext_oe_n === !(c >= oen), "R11 oe in chained burst", 64'(ext_oe_n),
          64'(!(c >= oen)));
    end
    @(negedge clk);
    chk_rsp(32'hB0B0_0002, 1'b0, 1'b0, 1'b1);
    chk({ext_cs_n, ext_oe_n} === 2'b11, "R10 strobes idle after chain",
        64'({ext_cs_n, ext_oe_n}), 64'h3);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_be = '0;
    cfg_csn_dly = '0; cfg_oen_dly = '0; cfg_first_wait = '0; cfg_beat_wait = '0;
    cfg_hold = '0; cfg_be_mode = 1'b0; cfg_par_en = 1'b0;
    ext_data = '0; ext_par = '0; ext_err = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_zero_delay;
    t_single;
    t_parity_on;
    t_parity_off;
    t_bus_err;
    t_long_hold;
    t_b2b(1, 0, 2);
    t_b2b(0, 2, 3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule